// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block keeps per-vector bookkeeping for 256 interrupt vectors: a pending set, an in-service set and a trigger-mode set. Requesters post a vector together with its trigger type, edge or level. The block finds the highest pending vector and works out a processor priority byte from the task priority and the class of the highest vector now in service. It offers the pending vector to the core only when that vector's class beats the processor priority. Each state set is kept as words of a parameterised width, eight 32-bit words by default. Vector v lives in word v>>5, bit v&31.

The core takes the offered vector with an acknowledge strobe and later retires it with an end-of-interrupt strobe. End-of-interrupt always retires the highest vector in service. If that vector was level-triggered, the block emits a one-cycle broadcast that carries the vector, so an upstream source can re-arm its line. A global enable gates new requests and the offer.

Top module: `vec_prio_ctrl`

## Requirements
- R1: After reset the pending, in-service and trigger-mode sets are empty, `ppr` is 0, `offer_valid` is 0 and `eoi_bc_valid` is 0.
- R2: `offer_vec` is the highest pending vector. `offer_valid` is 1 only when `ctrl_en` is 1, a vector is pending, and the vector with its low four bits cleared is strictly greater than the full 8-bit `ppr`.
- R3: Let C be the class (bits 7:4) of the highest in-service vector, with an empty set counting as vector 0. When tpr[7:4] >= C, `ppr` equals the 8-bit task priority. Otherwise `ppr` equals C followed by four zero bits.
- R4: A pulse on `tpr_wr` keeps only bits 7:0 of `tpr_data` as the new task priority, and `ppr` is recomputed.
- R5: `ack` while `offer_valid` is 1 sets the in-service bit of `offer_vec` and clears its pending bit. `ack` while `offer_valid` is 0 changes nothing.
- R6: `eoi` clears the highest in-service bit and recomputes `ppr`. If that vector's trigger-mode bit was 1 (level), the bit is cleared and `eoi_bc_valid` is 1 for exactly the next cycle, with `eoi_bc_vec` equal to the vector. An edge vector produces no broadcast.
- R7: `eoi` while nothing is in service changes no state and produces no broadcast.
- R8: A request made while `ctrl_en` is 0 is dropped.
- R9: A level request (`req_level`=1) for a vector that is already pending is dropped and leaves its trigger-mode bit unchanged. Any other accepted request sets the pending bit and sets the trigger-mode bit to `req_level`.
- R10: Requests for vectors 0 to 15 are ignored and never become pending.
- R11: When `ack` and `eoi` are both asserted in one cycle, the end-of-interrupt is applied first, to the in-service set as it stood before the acknowledge.
- R12: `ppr` is registered. After any clock edge that changes the task priority or the in-service set, it shows the new value, and the offer decision is based on that registered value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_en | input | 1 | Global enable for requests and the offer |
| req_valid | input | 1 | Request strobe |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_data | input | TPR_IN_W (32) | Task-priority write data; bits 7:0 are kept |
| ack | input | 1 | Core takes the offered vector |
| eoi | input | 1 | End-of-interrupt strobe |
| offer_valid | output | 1 | A vector is offered to the core |
| offer_vec | output | 8 | Offered (highest pending) vector |
| ppr | output | 8 | Registered processor priority |
| eoi_bc_valid | output | 1 | One-cycle broadcast for a retired level vector |
| eoi_bc_vec | output | 8 | Vector carried by the broadcast |

## Verification
The offer logic is tested with several pending sets spread over different words. The highest vector must win regardless of arrival order, and task-priority values just above and just below a class boundary show that the class comparison is strict. Nested acknowledges followed by end-of-interrupts show that `ppr` follows the in-service set, and separate level-triggered vectors from edge-triggered ones by whether a broadcast appears. Repeated requests in both trigger orders show the level-repeat drop apart from an edge re-request, which rewrites the trigger bit. A joint acknowledge and end-of-interrupt shows the ordering: the opposite order would leave a different `ppr` and a different broadcast.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
   localparam int unsigned VEC_W   = 8;
   localparam int unsigned NUM_VEC = 1 << VEC_W;
   localparam int unsigned CLASS_W = 4;

   typedef logic [VEC_W-1:0] vec_t;

   // vector with its sub-class bits cleared
   function automatic vec_t class_base(input vec_t v);
      return {v[VEC_W-1 -: CLASS_W], {(VEC_W-CLASS_W){1'b0}}};
   endfunction
endpackage

// File: rtl/vpc_find_top.sv
// Highest-set-bit finder over a word-organised bit set.
module vpc_find_top #(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned NUM_WORDS = 8,
   parameter int unsigned SCAN_MODE = 0,   // 0: word then bit, 1: flat
   localparam int unsigned TOTAL    = WORD_W * NUM_WORDS,
   localparam int unsigned IDX_W    = $clog2(TOTAL)
) (
   input  logic [TOTAL-1:0] bits,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   localparam int unsigned BIT_W  = $clog2(WORD_W);
   localparam int unsigned WSEL_W = $clog2(NUM_WORDS);

   if (WORD_W < 2 || (1 << BIT_W) != WORD_W) begin : g_bad_word
      $error("WORD_W must be a power of two of at least 2");
   end
   if (NUM_WORDS < 2 || (1 << WSEL_W) != NUM_WORDS) begin : g_bad_count
      $error("NUM_WORDS must be a power of two of at least 2");
   end

   if (SCAN_MODE == 0) begin : g_two_level
      logic [NUM_WORDS-1:0] word_any;
      logic [WSEL_W-1:0]    wsel;
      logic [BIT_W-1:0]     bsel;
      logic [WORD_W-1:0]    word;

      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_any
         assign word_any[w] = |bits[w*WORD_W +: WORD_W];
      end

      // upward loop: the last hit is the top non-empty word
      always_comb begin
         wsel = '0;
         for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_any[w]) wsel = WSEL_W'(w);
         end
      end

      assign word = bits[{wsel, {BIT_W{1'b0}}} +: WORD_W];

      always_comb begin
         bsel = '0;
         for (int b = 0; b < WORD_W; b++) begin
            if (word[b]) bsel = BIT_W'(b);
         end
      end

      assign found = |word_any;
      assign idx   = {wsel, bsel};
   end else begin : g_flat
      always_comb begin
         idx = '0;
         for (int i = 0; i < TOTAL; i++) begin
            if (bits[i]) idx = IDX_W'(i);
         end
      end
      assign found = |bits;
   end
endmodule

// File: rtl/vpc_ppr_calc.sv
// Processor priority from task priority and top in-service vector.
module vpc_ppr_calc
   import vpc_pkg::*;
(
   input  vec_t tpr,
   input  logic isr_found,
   input  vec_t isr_top,
   output vec_t ppr
);
   vec_t isr_eff;

   assign isr_eff = isr_found ? isr_top : '0;

   always_comb begin
      if (tpr[VEC_W-1 -: CLASS_W] >= isr_eff[VEC_W-1 -: CLASS_W]) ppr = tpr;
      else                                                      ppr = class_base(isr_eff);
   end
endmodule

// File: rtl/vpc_state.sv
// Pending / in-service / trigger-mode sets and their update order.
module vpc_state
   import vpc_pkg::*;
#(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned RSVD_VEC  = 16,
   localparam int unsigned NUM_WORDS = NUM_VEC / WORD_W,
   localparam int unsigned BIT_W     = $clog2(WORD_W)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              ctrl_en,
   input  logic                              req_valid,
   input  vec_t                              req_vec,
   input  logic                              req_level,
   input  logic                              ack_take,
   input  vec_t                              ack_vec,
   input  logic                              eoi_take,
   input  vec_t                              eoi_vec,
   output logic [NUM_WORDS-1:0][WORD_W-1:0] irr_q,
   output logic [NUM_WORDS-1:0][WORD_W-1:0] isr_q,
   output logic [NUM_WORDS-1:0][WORD_W-1:0] isr_d,
   output logic                              eoi_is_level
);
   logic [NUM_WORDS-1:0][WORD_W-1:0] tmr_q, tmr_d, irr_d;
   logic                             req_ok;

   // word / bit split of each incoming vector
   logic [VEC_W-BIT_W-1:0] rw, aw, ew;
   logic [BIT_W-1:0]       rb, ab, eb;

   assign {rw, rb} = req_vec;
   assign {aw, ab} = ack_vec;
   assign {ew, eb} = eoi_vec;

   assign eoi_is_level = tmr_q[ew][eb];

   assign req_ok = req_valid && ctrl_en && (req_vec >= vec_t'(RSVD_VEC))
                   && !(req_level && irr_q[rw][rb]);

   always_comb begin
      irr_d = irr_q;
      isr_d = isr_q;
      tmr_d = tmr_q;
      // end-of-interrupt first
      if (eoi_take) begin
         isr_d[ew][eb] = 1'b0;
         tmr_d[ew][eb] = 1'b0;
      end
      // then acknowledge
      if (ack_take) begin
         isr_d[aw][ab] = 1'b1;
         irr_d[aw][ab] = 1'b0;
      end
      // then the new request
      if (req_ok) begin
         irr_d[rw][rb] = 1'b1;
         tmr_d[rw][rb] = req_level;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_q <= '0;
         isr_q <= '0;
         tmr_q <= '0;
      end else begin
         irr_q <= irr_d;
         isr_q <= isr_d;
         tmr_q <= tmr_d;
      end
   end
endmodule

// File: rtl/vec_prio_ctrl.sv
module vec_prio_ctrl
   import vpc_pkg::*;
#(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned RSVD_VEC  = 16,
   parameter int unsigned TPR_IN_W  = 32,
   parameter int unsigned SCAN_MODE = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ctrl_en,
   input  logic                req_valid,
   input  logic [7:0]          req_vec,
   input  logic                req_level,
   input  logic                tpr_wr,
   input  logic [TPR_IN_W-1:0] tpr_data,
   input  logic                ack,
   input  logic                eoi,
   output logic                offer_valid,
   output logic [7:0]          offer_vec,
   output logic [7:0]          ppr,
   output logic                eoi_bc_valid,
   output logic [7:0]          eoi_bc_vec
);
   localparam int unsigned NUM_WORDS = NUM_VEC / WORD_W;

   if (NUM_WORDS * WORD_W != NUM_VEC) begin : g_bad_split
      $error("WORD_W must divide the vector count");
   end
   if (TPR_IN_W < VEC_W) begin : g_bad_tpr
      $error("TPR_IN_W must hold a full priority byte");
   end
   if (RSVD_VEC >= NUM_VEC) begin : g_bad_rsvd
      $error("RSVD_VEC leaves no usable vector");
   end

   logic [NUM_WORDS-1:0][WORD_W-1:0] irr_q, isr_q, isr_d;
   logic eoi_is_level;
   logic irr_found, isr_found, isr_found_d;
   vec_t irr_top, isr_top, isr_top_d;
   vec_t tpr_q, tpr_d, ppr_q, ppr_d;
   logic ack_take, eoi_take;
   logic bc_valid_q;
   vec_t bc_vec_q;
   logic unused_tpr_hi;

   if (TPR_IN_W > VEC_W) begin : g_tpr_hi
      assign unused_tpr_hi = ^tpr_data[TPR_IN_W-1:VEC_W];
   end else begin : g_tpr_exact
      assign unused_tpr_hi = 1'b0;
   end

   // scans of the current pending and in-service sets
   vpc_find_top #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .SCAN_MODE(SCAN_MODE)) u_scan_irr (
      .bits(irr_q), .found(irr_found), .idx(irr_top));
   vpc_find_top #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .SCAN_MODE(SCAN_MODE)) u_scan_isr (
      .bits(isr_q), .found(isr_found), .idx(isr_top));
   // scan of the next in-service set, feeding the priority register
   vpc_find_top #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .SCAN_MODE(SCAN_MODE)) u_scan_isr_d (
      .bits(isr_d), .found(isr_found_d), .idx(isr_top_d));

   assign offer_valid = ctrl_en && irr_found && (class_base(irr_top) > ppr_q);
   assign offer_vec   = irr_found ? irr_top : '0;

   assign ack_take = ack && offer_valid;
   assign eoi_take = eoi && isr_found;

   vpc_state #(.WORD_W(WORD_W), .RSVD_VEC(RSVD_VEC)) u_state (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl_en     (ctrl_en),
      .req_valid   (req_valid),
      .req_vec     (req_vec),
      .req_level   (req_level),
      .ack_take    (ack_take),
      .ack_vec     (offer_vec),
      .eoi_take    (eoi_take),
      .eoi_vec     (isr_top),
      .irr_q       (irr_q),
      .isr_q       (isr_q),
      .isr_d       (isr_d),
      .eoi_is_level(eoi_is_level)
   );

   assign tpr_d = tpr_wr ? tpr_data[VEC_W-1:0] : tpr_q;

   vpc_ppr_calc u_ppr (
      .tpr      (tpr_d),
      .isr_found(isr_found_d),
      .isr_top  (isr_top_d),
      .ppr      (ppr_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tpr_q      <= '0;
         ppr_q      <= '0;
         bc_valid_q <= 1'b0;
         bc_vec_q   <= '0;
      end else begin
         tpr_q      <= tpr_d;
         ppr_q      <= ppr_d;
         bc_valid_q <= eoi_take && eoi_is_level;
         bc_vec_q   <= (eoi_take && eoi_is_level) ? isr_top : '0;
      end
   end

   assign ppr          = ppr_q;
   assign eoi_bc_valid = bc_valid_q;
   assign eoi_bc_vec   = bc_vec_q;
endmodule

// File: rtl/vpc_checker.sv
module vpc_checker #(
   parameter int unsigned NUM_VEC  = 256,
   parameter int unsigned RSVD_VEC = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ctrl_en,
   input logic               req_valid,
   input logic [7:0]         req_vec,
   input logic               ack,
   input logic               eoi,
   input logic               offer_valid,
   input logic [7:0]         offer_vec,
   input logic [7:0]         ppr,
   input logic               eoi_bc_valid,
   input logic [NUM_VEC-1:0] irr,
   input logic [NUM_VEC-1:0] isr
);
   AST_OFFER_ABOVE_PPR: assert property (@(posedge clk) disable iff (!rst_n)
      offer_valid |-> ({offer_vec[7:4], 4'h0} > ppr));                      // R2

   AST_OFFER_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en |-> !offer_valid);                                           // R2

   AST_ACK_MOVES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && offer_valid) |=> isr[$past(offer_vec)]);                      // R5

   AST_BC_AFTER_EOI: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_bc_valid |-> $past(eoi));                                         // R6

   AST_EOI_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && (isr == '0)) |=> !eoi_bc_valid);                              // R7

   AST_DROP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_en && req_valid && !irr[req_vec]) |=> !irr[$past(req_vec)]);   // R8

   AST_RSVD_NEVER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      irr[RSVD_VEC-1:0] == '0);                                             // R10
endmodule

bind vec_prio_ctrl vpc_checker #(.NUM_VEC(vpc_pkg::NUM_VEC), .RSVD_VEC(RSVD_VEC)) u_vpc_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctrl_en     (ctrl_en),
   .req_valid   (req_valid),
   .req_vec     (req_vec),
   .ack         (ack),
   .eoi         (eoi),
   .offer_valid (offer_valid),
   .offer_vec   (offer_vec),
   .ppr         (ppr),
   .eoi_bc_valid(eoi_bc_valid),
   .irr         (irr_q),
   .isr         (isr_q)
);

// File: tb/vec_prio_ctrl_bench.sv
`timescale 1ns/1ps
module vec_prio_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_en = 1'b1;
   logic        req_valid = 1'b0;
   logic [7:0]  req_vec = '0;
   logic        req_level = 1'b0;
   logic        tpr_wr = 1'b0;
   logic [31:0] tpr_data = '0;
   logic        ack = 1'b0;
   logic        eoi = 1'b0;
   logic        offer_valid;
   logic [7:0]  offer_vec;
   logic [7:0]  ppr;
   logic        eoi_bc_valid;
   logic [7:0]  eoi_bc_vec;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #4 clk = ~clk;   // 125 MHz

   vec_prio_ctrl u_vec_prio_ctrl (
      .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en),
      .req_valid(req_valid), .req_vec(req_vec), .req_level(req_level),
      .tpr_wr(tpr_wr), .tpr_data(tpr_data), .ack(ack), .eoi(eoi),
      .offer_valid(offer_valid), .offer_vec(offer_vec), .ppr(ppr),
      .eoi_bc_valid(eoi_bc_valid), .eoi_bc_vec(eoi_bc_vec)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 100000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; ctrl_en = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic post(input logic [7:0] v, input logic lvl);
      @(negedge clk);
      req_valid = 1'b1; req_vec = v; req_level = lvl;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic take();
      @(negedge clk); ack = 1'b1;
      @(negedge clk); ack = 1'b0;
   endtask

   task automatic retire();
      @(negedge clk); eoi = 1'b1;
      @(negedge clk); eoi = 1'b0;
   endtask

   task automatic set_tpr(input logic [31:0] d);
      @(negedge clk); tpr_wr = 1'b1; tpr_data = d;
      @(negedge clk); tpr_wr = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 offer_valid", offer_valid, 0);
      chk("R1 ppr", ppr, 0);
      chk("R1 eoi_bc_valid", eoi_bc_valid, 0);
   endtask

   task automatic t_highest();
      do_reset();
      post(8'h45, 0);
      chk("R2 single offer", offer_vec, 8'h45);
      post(8'h30, 0);
      chk("R2 lower arrival keeps top", offer_vec, 8'h45);
      post(8'hA2, 0);
      chk("R2 higher word wins", offer_vec, 8'hA2);
      chk("R2 offer_valid", offer_valid, 1);
      set_tpr(32'h0000_00A5);
      chk("R4 ppr from tpr", ppr, 8'hA5);
      chk("R2 equal class not offered", offer_valid, 0);
      set_tpr(32'h0000_009F);
      chk("R2 class just above offered", offer_valid, 1);
      set_tpr(32'h1234_5691);
      chk("R4 upper bits dropped", ppr, 8'h91);
   endtask

   task automatic t_ack_eoi();
      do_reset();
      post(8'h45, 1);
      @(negedge clk); ack = 1'b1;
      chk("R12 ppr unchanged before edge", ppr, 8'h00);
      @(negedge clk); ack = 1'b0;
      chk("R12 ppr after ack edge", ppr, 8'h40);
      chk("R5 acked vector no longer offered", offer_valid, 0);
      set_tpr(32'h50);
      chk("R3 tpr class wins", ppr, 8'h50);
      set_tpr(32'h00);
      chk("R3 isr class wins", ppr, 8'h40);
      post(8'h92, 0);
      chk("R2 nested offer", offer_vec, 8'h92);
      take();
      chk("R3 nested ppr", ppr, 8'h90);
      retire();
      chk("R6 edge retire no broadcast", eoi_bc_valid, 0);
      chk("R6 ppr falls to next in service", ppr, 8'h40);
      retire();
      chk("R6 level broadcast valid", eoi_bc_valid, 1);
      chk("R6 level broadcast vector", eoi_bc_vec, 8'h45);
      chk("R6 ppr empty", ppr, 8'h00);
      chk("R5 pending cleared by ack", offer_valid, 0);
      @(negedge clk);
      chk("R6 broadcast one cycle", eoi_bc_valid, 0);
      retire();
      chk("R7 empty eoi no broadcast", eoi_bc_valid, 0);
      chk("R7 empty eoi ppr", ppr, 8'h00);
      take();
      chk("R5 ack without offer", ppr, 8'h00);
   endtask

   task automatic t_disabled();
      do_reset();
      ctrl_en = 1'b0;
      post(8'h50, 0);
      ctrl_en = 1'b1;
      @(negedge clk);
      chk("R8 dropped while disabled", offer_valid, 0);
      post(8'h50, 0);
      chk("R8 accepted when enabled", offer_vec, 8'h50);
      ctrl_en = 1'b0;
      @(negedge clk);
      chk("R2 offer gated by enable", offer_valid, 0);
      take();
      chk("R5 ack ignored while gated", ppr, 8'h00);
      ctrl_en = 1'b1;
      @(negedge clk);
      chk("R2 offer returns", offer_vec, 8'h50);
   endtask

   task automatic t_level_repeat();
      do_reset();
      post(8'h60, 0);
      post(8'h60, 1);
      take();
      retire();
      chk("R9 level repeat left trigger edge", eoi_bc_valid, 0);
      post(8'h70, 1);
      post(8'h70, 0);
      take();
      retire();
      chk("R9 edge re-request clears trigger", eoi_bc_valid, 0);
      post(8'h80, 1);
      post(8'h80, 1);
      take();
      chk("R9 single pending after repeat", offer_valid, 0);
      retire();
      chk("R9 level broadcast", eoi_bc_vec, 8'h80);
   endtask

   task automatic t_reserved();
      do_reset();
      post(8'h0F, 0);
      chk("R10 low vector not pending", offer_vec, 8'h00);
      post(8'h10, 0);
      chk("R10 first usable vector", offer_vec, 8'h10);
   endtask

   task automatic t_same_cycle();
      do_reset();
      post(8'h35, 0);
      take();
      chk("R3 ppr after first ack", ppr, 8'h30);
      post(8'h82, 1);
      chk("R11 offer before joint cycle", offer_vec, 8'h82);
      @(negedge clk); ack = 1'b1; eoi = 1'b1;
      @(negedge clk); ack = 1'b0; eoi = 1'b0;
      chk("R11 eoi applied first ppr", ppr, 8'h80);
      chk("R11 retired edge vector quiet", eoi_bc_valid, 0);
      retire();
      chk("R11 new vector then retired", eoi_bc_vec, 8'h82);
   endtask

   initial begin
      t_reset();
      t_highest();
      t_ack_eoi();
      t_disabled();
      t_level_repeat();
      t_reserved();
      t_same_cycle();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule